// File: doc/BRIEF.md
# BCD Calendar Register Bank with Buffered Readout

The block keeps time of day and calendar date in packed BCD counters that advance once per second, and shows them to software through eight byte-wide holding registers decoded at the highest eight addresses of the bus. The counters advance on a one-second strobe. A prescaler produces that strobe from the system clock, and it runs only while the oscillator is enabled. Software sees a copy of the counters and never the counters themselves. The copy follows the counters every clock cycle unless one of two halt bits in the control register freezes it.

Software sets the read-halt bit to take a coherent snapshot while timekeeping continues underneath. To set the time, software sets the write-halt bit, writes the new values into the holding registers, then clears the bit. Clearing it loads the counters and restarts the prescaler so the loaded second lasts a full second. Three more controls sit in the same registers: a stop bit halts timekeeping, a test bit replaces the seconds LSB on readout with a 512 Hz square wave, and a read-only flag reports battery health.

Top module: `rtc_bcd_regs`

## Requirements
- R1: A bus cycle decodes to the bank only when every address bit above bit 2 is 1 (hit_o high). Bits 2:0 select the register: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. With no hit, rdata_o is 0 and writes change nothing.
- R2: After reset the bank reads century 00, year 00, month 01, date 01, day 1, 00:00:00, with all control bits 0.
- R3: With the oscillator running, seconds advance once every 1024*CYC_PER_HALF clock cycles, counted from the counter load. Seconds wrap 59 to 00 into minutes, minutes wrap 59 to 00 into hours, and hours wrap 23 to 00 into the date.
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and in month 02 after 29 when the BCD year is a multiple of 4 (00 included) and after 28 otherwise. Month 12 wraps to 01 and steps the year. Year 99 wraps to 00 and steps the century, and century 39 wraps to 00.
- R5: Day of week steps with each date change and wraps from 7 to 1.
- R6: While control bit 6 (read-halt) is 1, the holding registers keep the value the counters had when the bit was set, and the counters keep counting. After the bit is cleared, the next read shows the current count. Control bit 6 reads back as written.
- R7: Setting control bit 7 (write-halt) stops the holding registers from following the counters, so bus writes land in them. Clearing bit 7 loads all counters from the holding registers and restarts the prescaler. This works the same way while the read-halt bit is also set.
- R8: Seconds bit 7 is the oscillator stop bit and reads back as written. While it is 1, the counters do not advance. Once it is cleared, counting resumes.
- R9: Day bit 6 is the frequency test bit. While it is 1 and the oscillator runs, the seconds LSB as read inverts every CYC_PER_HALF cycles. While the oscillator is stopped, the LSB does not change.
- R10: Day bit 7 reads the level of batt_ok_i, and bus writes have no effect on it.
- R11: The unused bits read as 0 whatever value is written to them: month bits 7:5, date and hour bits 7:6, minutes bit 7, and day bits 5:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| batt_ok_i | input | 1 | Battery status level, 1 = good |
| sel_i | input | 1 | Bus cycle valid |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register, 0 on no hit |
| hit_o | output | 1 | Address falls in the top eight locations |

## Verification
The calendar carries that reach the year and century digits only happen after long runs of natural counting, far too long to reach by waiting. The bench instead loads a value one second before each boundary through the write-halt sequence. Because clearing that bit restarts the prescaler, the bench knows the tick cycle exactly and samples half a second before it and half a second after it. Read-halt and stop are checked by waiting several seconds and comparing the frozen readout with the count that continued underneath.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [5:0] cent;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] day;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RST = '{cent: 6'h00, yr: 8'h00, mon: 5'h01, date: 6'h01,
                                    day: 3'd1, hr: 6'h00, min: 7'h00, sec: 7'h00};

  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_SEC  = 3'd1;
  localparam logic [2:0] IDX_MIN  = 3'd2;
  localparam logic [2:0] IDX_HR   = 3'd3;
  localparam logic [2:0] IDX_DAY  = 3'd4;
  localparam logic [2:0] IDX_DATE = 3'd5;
  localparam logic [2:0] IDX_MON  = 3'd6;
  localparam logic [2:0] IDX_YR   = 3'd7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by 4
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned CYC_PER_HALF = 32,
  parameter int unsigned HALF_PER_SEC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic half_o,
  output logic sec_o,
  output logic sq_o
);
  localparam int unsigned SUB_W = $clog2(HALF_PER_SEC);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF_PER_SEC - 1);

  logic             half;
  logic [SUB_W-1:0] sub_q;
  logic             sq_q;

  generate
    if (CYC_PER_HALF > 1) begin : g_div
      localparam int unsigned DIV_W = $clog2(CYC_PER_HALF);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_PER_HALF - 1);
      logic [DIV_W-1:0] div_q;
      assign half = run_i && (div_q == DIV_LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    div_q <= '0;
        else if (clr_i) div_q <= '0;
        else if (run_i) div_q <= half ? '0 : div_q + DIV_W'(1);
      end
    end else begin : g_nodiv
      assign half = run_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      sq_q  <= 1'b0;
    end else if (clr_i) begin
      sub_q <= '0;
      sq_q  <= 1'b0;
    end else if (half) begin
      sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + SUB_W'(1);
      sq_q  <= ~sq_q;
    end
  end

  assign half_o = half;
  assign sec_o  = half && (sub_q == SUB_LAST);
  assign sq_o   = sq_q;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o
);
  rtc_time_t  cnt_q, nxt;
  logic       sec_w, min_w, hr_w, date_w, mon_w, yr_w;
  logic [7:0] i_sec, i_min, i_hr, i_date, i_mon, i_cent;

  always_comb begin
    i_sec  = bcd_inc({1'b0, cnt_q.sec});
    i_min  = bcd_inc({1'b0, cnt_q.min});
    i_hr   = bcd_inc({2'b0, cnt_q.hr});
    i_date = bcd_inc({2'b0, cnt_q.date});
    i_mon  = bcd_inc({3'b0, cnt_q.mon});
    i_cent = bcd_inc({2'b0, cnt_q.cent});

    // >= keeps an out-of-range load from running away
    sec_w  = cnt_q.sec >= 7'h59;
    min_w  = sec_w && (cnt_q.min >= 7'h59);
    hr_w   = min_w && (cnt_q.hr >= 6'h23);
    date_w = hr_w && (cnt_q.date >= last_date(cnt_q.mon, is_leap(cnt_q.yr)));
    mon_w  = date_w && (cnt_q.mon >= 5'h12);
    yr_w   = mon_w && (cnt_q.yr >= 8'h99);

    nxt     = cnt_q;
    nxt.sec = sec_w ? 7'h00 : i_sec[6:0];
    if (sec_w) nxt.min = min_w ? 7'h00 : i_min[6:0];
    if (min_w) nxt.hr  = hr_w ? 6'h00 : i_hr[5:0];
    if (hr_w) begin
      nxt.date = date_w ? 6'h01 : i_date[5:0];
      nxt.day  = (cnt_q.day >= 3'd7) ? 3'd1 : cnt_q.day + 3'd1;
    end
    if (date_w) nxt.mon  = mon_w ? 5'h01 : i_mon[4:0];
    if (mon_w)  nxt.yr   = yr_w ? 8'h00 : bcd_inc(cnt_q.yr);
    if (yr_w)   nxt.cent = (cnt_q.cent >= 6'h39) ? 6'h00 : i_cent[5:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RTC_RST;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] idx_i,
  input  logic [7:0] wdata_i,
  input  rtc_time_t  cnt_i,
  input  logic       batt_i,
  input  logic       sq_i,
  output logic [7:0] rdata_o,
  output rtc_time_t  hold_o,
  output logic       load_o,
  output logic       stop_o,
  output logic       rd_o,
  output logic       wr_o
);
  rtc_time_t hold_q;
  logic      rd_q, wr_q, stop_q, ft_q, load_q;
  logic      halt;

  assign halt = rd_q || wr_q || load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      stop_q <= 1'b0;
      ft_q   <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= we_i && (idx_i == IDX_CTRL) && wr_q && !wdata_i[7];
      if (we_i) begin
        case (idx_i)
          IDX_CTRL: begin
            wr_q <= wdata_i[7];
            rd_q <= wdata_i[6];
          end
          IDX_SEC: stop_q <= wdata_i[7];
          IDX_DAY: ft_q   <= wdata_i[6];
          default: ;
        endcase
      end
    end
  end

  // holding copy follows counters unless halted; writes land only while halted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= RTC_RST;
    end else if (!halt) begin
      hold_q <= cnt_i;
    end else if (we_i) begin
      case (idx_i)
        IDX_CTRL: hold_q.cent <= wdata_i[5:0];
        IDX_SEC:  hold_q.sec  <= wdata_i[6:0];
        IDX_MIN:  hold_q.min  <= wdata_i[6:0];
        IDX_HR:   hold_q.hr   <= wdata_i[5:0];
        IDX_DAY:  hold_q.day  <= wdata_i[2:0];
        IDX_DATE: hold_q.date <= wdata_i[5:0];
        IDX_MON:  hold_q.mon  <= wdata_i[4:0];
        default:  hold_q.yr   <= wdata_i;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      IDX_CTRL: rdata_o = {wr_q, rd_q, hold_q.cent};
      IDX_SEC:  rdata_o = {stop_q, hold_q.sec[6:1], (ft_q && !stop_q) ? sq_i : hold_q.sec[0]};
      IDX_MIN:  rdata_o = {1'b0, hold_q.min};
      IDX_HR:   rdata_o = {2'b0, hold_q.hr};
      IDX_DAY:  rdata_o = {batt_i, ft_q, 3'b0, hold_q.day};
      IDX_DATE: rdata_o = {2'b0, hold_q.date};
      IDX_MON:  rdata_o = {3'b0, hold_q.mon};
      default:  rdata_o = hold_q.yr;
    endcase
  end

  assign hold_o = hold_q;
  assign load_o = load_q;
  assign stop_o = stop_q;
  assign rd_o   = rd_q;
  assign wr_o   = wr_q;
endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned CYC_PER_HALF = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              batt_ok_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              hit_o
);
  localparam int unsigned IDX_W        = 3;
  localparam int unsigned HALF_PER_SEC = 1024;

  logic       hit, bus_we, load, osc_stop, rd_bit, wr_bit;
  logic       half_tick, sec_tick, sq;
  logic [7:0] rf_rdata;
  rtc_time_t  cnt, hold;

  assign hit    = &addr_i[ADDR_W-1:IDX_W];
  assign bus_we = sel_i && we_i && hit;

  rtc_prescaler #(
    .CYC_PER_HALF(CYC_PER_HALF),
    .HALF_PER_SEC(HALF_PER_SEC)
  ) i_prescaler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (!osc_stop),
    .clr_i (load),
    .half_o(half_tick),
    .sec_o (sec_tick),
    .sq_o  (sq)
  );

  rtc_calendar i_calendar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sec_tick),
    .load_i    (load),
    .load_val_i(hold),
    .cnt_o     (cnt)
  );

  rtc_regfile i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bus_we),
    .idx_i  (addr_i[IDX_W-1:0]),
    .wdata_i(wdata_i),
    .cnt_i  (cnt),
    .batt_i (batt_ok_i),
    .sq_i   (sq),
    .rdata_o(rf_rdata),
    .hold_o (hold),
    .load_o (load),
    .stop_o (osc_stop),
    .rd_o   (rd_bit),
    .wr_o   (wr_bit)
  );

  assign rdata_o = hit ? rf_rdata : 8'h00;
  assign hit_o   = hit;
endmodule

// File: rtl/rtc_bcd_regs_chk.sv
module rtc_bcd_regs_chk
  import rtc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input rtc_time_t  cnt_i,
  input rtc_time_t  hold_i,
  input logic       load_i,
  input logic       tick_i,
  input logic       stop_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic       bus_we_i,
  input logic       hit_i,
  input logic [2:0] idx_i,
  input logic       batt_i,
  input logic [7:0] rdata_i
);
  p_sec_bcd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i.sec <= 7'h59) && (cnt_i.sec[3:0] <= 4'd9));

  p_hr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i.hr <= 6'h23);

  p_month_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && (cnt_i.hr == 6'h23) && (cnt_i.min == 7'h59) && (cnt_i.sec == 7'h59)
     && (cnt_i.date >= last_date(cnt_i.mon, is_leap(cnt_i.yr))))
    |=> (cnt_i.date == 6'h01));

  p_day_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i.day >= 3'd1) && (cnt_i.day <= 3'd7));

  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $past(rd_i) && !$past(bus_we_i)) |-> $stable(hold_i));

  p_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i && !load_i) |=> (hold_i == $past(cnt_i)));

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_i == $past(hold_i)));

  p_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !tick_i);

  p_batt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && (idx_i == IDX_DAY)) |-> (rdata_i[7] == batt_i));
endmodule

bind rtc_bcd_regs rtc_bcd_regs_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_i   (cnt),
  .hold_i  (hold),
  .load_i  (load),
  .tick_i  (sec_tick),
  .stop_i  (osc_stop),
  .rd_i    (rd_bit),
  .wr_i    (wr_bit),
  .bus_we_i(bus_we),
  .hit_i   (hit_o),
  .idx_i   (addr_i[2:0]),
  .batt_i  (batt_ok_i),
  .rdata_i (rdata_o)
);

// File: tb/test_rtc_bcd_regs.sv
module test_rtc_bcd_regs;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 17;
  localparam int HALF   = 2;
  localparam int SEC    = 1024 * HALF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              batt = 1'b1;
  logic              sel = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              hit;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_bcd_regs #(.ADDR_W(ADDR_W), .CYC_PER_HALF(HALF)) i_rtc_bcd_regs (
    .clk_i(clk), .rst_ni(rst_n), .batt_ok_i(batt), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .hit_o(hit)
  );

  function automatic logic [ADDR_W-1:0] top_addr(input logic [2:0] idx);
    return {{(ADDR_W-3){1'b1}}, idx};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr_a(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_wr(input logic [2:0] idx, input logic [7:0] d);
    bus_wr_a(top_addr(idx), d);
  endtask

  task automatic bus_rd(input logic [2:0] idx, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = top_addr(idx);
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] idx, input logic [7:0] exp);
    logic [7:0] d;
    bus_rd(idx, d);
    chk(tag, d, exp);
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, d, dw, h, mi, s);
    bus_wr(3'd0, 8'h80 | c);
    bus_wr(3'd7, y);
    bus_wr(3'd6, mo);
    bus_wr(3'd5, d);
    bus_wr(3'd4, dw);
    bus_wr(3'd3, h);
    bus_wr(3'd2, mi);
    bus_wr(3'd1, s);
    bus_wr(3'd0, c);
  endtask

  task automatic chk_time(input string tag, input logic [7:0] c, y, mo, d, dw, h, mi, s);
    rd_chk(tag, 3'd0, c);
    rd_chk(tag, 3'd7, y);
    rd_chk(tag, 3'd6, mo);
    rd_chk(tag, 3'd5, d);
    rd_chk(tag, 3'd4, {1'b1, 4'b0, dw[2:0]});
    rd_chk(tag, 3'd3, h);
    rd_chk(tag, 3'd2, mi);
    rd_chk(tag, 3'd1, s);
  endtask

  task automatic t_reset;
    chk_time("R2 reset", 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_decode;
    logic [7:0] d;
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = 17'h00001;
    #1 chk("R1 hit low addr", {7'b0, hit}, 8'h00);
    chk("R1 rdata low addr", rdata, 8'h00);
    addr = top_addr(3'd1);
    #1 chk("R1 hit top addr", {7'b0, hit}, 8'h01);
    sel = 1'b0;
    bus_wr_a(17'h0FFF9, 8'h80);
    bus_rd(3'd1, d);
    chk("R1 write outside ignored", d[7:7], 1'b0);
  endtask

  task automatic t_carry;
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC/2);
    rd_chk("R3 before tick", 3'd1, 8'h59);
    wait_cyc(SEC);
    chk_time("R3 R4 R5 carry", 8'h20, 8'h23, 8'h03, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_min_carry;
    set_time(8'h20, 8'h23, 8'h06, 8'h10, 8'h03, 8'h10, 8'h00, 8'h59);
    wait_cyc(SEC + SEC/2);
    rd_chk("R3 min carry sec", 3'd1, 8'h00);
    rd_chk("R3 min carry min", 3'd2, 8'h01);
    rd_chk("R3 min carry hr", 3'd3, 8'h10);
  endtask

  task automatic t_months;
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC + SEC/2);
    rd_chk("R4 leap feb28", 3'd5, 8'h29);
    rd_chk("R4 leap feb28 mon", 3'd6, 8'h02);
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC + SEC/2);
    rd_chk("R4 feb29 date", 3'd5, 8'h01);
    rd_chk("R4 feb29 mon", 3'd6, 8'h03);
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC + SEC/2);
    rd_chk("R4 year00 leap", 3'd5, 8'h29);
    set_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC + SEC/2);
    rd_chk("R4 apr30 date", 3'd5, 8'h01);
    rd_chk("R4 apr30 mon", 3'd6, 8'h05);
  endtask

  task automatic t_year;
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC + SEC/2);
    chk_time("R4 year end", 8'h21, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
    set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    wait_cyc(SEC + SEC/2);
    rd_chk("R4 century wrap", 3'd0, 8'h00);
    rd_chk("R5 day wrap", 3'd4, 8'h81);
  endtask

  task automatic t_read_halt;
    set_time(8'h20, 8'h23, 8'h05, 8'h10, 8'h01, 8'h08, 8'h00, 8'h00);
    wait_cyc(SEC/4);
    bus_wr(3'd0, 8'h60);
    rd_chk("R6 read bit readback", 3'd0, 8'h60);
    wait_cyc(SEC*2 + SEC/2);
    rd_chk("R6 frozen", 3'd1, 8'h00);
    bus_wr(3'd0, 8'h20);
    rd_chk("R6 refreshed", 3'd1, 8'h02);
  endtask

  task automatic t_write_prio;
    set_time(8'h20, 8'h23, 8'h05, 8'h10, 8'h01, 8'h05, 8'h00, 8'h00);
    bus_wr(3'd0, 8'h60);
    bus_wr(3'd0, 8'hE0);
    bus_wr(3'd1, 8'h30);
    bus_wr(3'd2, 8'h15);
    bus_wr(3'd0, 8'h60);
    wait_cyc(SEC/2);
    bus_wr(3'd0, 8'h20);
    rd_chk("R7 prio sec", 3'd1, 8'h30);
    rd_chk("R7 prio min", 3'd2, 8'h15);
  endtask

  task automatic t_osc_stop;
    set_time(8'h20, 8'h23, 8'h05, 8'h10, 8'h01, 8'h12, 8'h34, 8'h56);
    wait_cyc(SEC/4);
    bus_wr(3'd1, 8'h80);
    wait_cyc(SEC*2 + SEC/2);
    rd_chk("R8 stopped", 3'd1, 8'hD6);
    bus_wr(3'd1, 8'h00);
    wait_cyc(SEC + SEC/5);
    rd_chk("R8 resumed", 3'd1, 8'h57);
  endtask

  task automatic t_freq;
    logic prev;
    int   n;
    bus_wr(3'd4, 8'h41);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = top_addr(3'd1);
    #1 prev = rdata[0];
    n = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      #1 if (rdata[0] != prev) n++;
      prev = rdata[0];
    end
    sel = 1'b0;
    chk("R9 toggles running", 8'(n), 8'd16);
    bus_wr(3'd1, 8'h80);
    @(negedge clk);
    sel = 1'b1; addr = top_addr(3'd1);
    #1 prev = rdata[0];
    n = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      #1 if (rdata[0] != prev) n++;
      prev = rdata[0];
    end
    sel = 1'b0;
    chk("R9 toggles stopped", 8'(n), 8'd0);
    bus_wr(3'd1, 8'h00);
    bus_wr(3'd4, 8'h01);
  endtask

  task automatic t_batt;
    logic [7:0] d;
    batt = 1'b0;
    bus_rd(3'd4, d);
    chk("R10 batt low", {7'b0, d[7]}, 8'h00);
    bus_wr(3'd4, 8'h80 | {5'b0, d[2:0]});
    bus_rd(3'd4, d);
    chk("R10 write ignored", {7'b0, d[7]}, 8'h00);
    batt = 1'b1;
    bus_rd(3'd4, d);
    chk("R10 batt good", {7'b0, d[7]}, 8'h01);
  endtask

  task automatic t_unused;
    bus_wr(3'd0, 8'hA0);
    bus_wr(3'd6, 8'hE1);
    rd_chk("R11 month mask", 3'd6, 8'h01);
    bus_wr(3'd5, 8'hC5);
    rd_chk("R11 date mask", 3'd5, 8'h05);
    bus_wr(3'd3, 8'hC7);
    rd_chk("R11 hour mask", 3'd3, 8'h07);
    bus_wr(3'd2, 8'h92);
    rd_chk("R11 min mask", 3'd2, 8'h12);
    bus_wr(3'd4, 8'h3B);
    rd_chk("R11 day mask", 3'd4, 8'h83);
    rd_chk("R7 held while write bit", 3'd0, 8'hA0);
    bus_wr(3'd0, 8'h20);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset;
    t_decode;
    t_carry;
    t_min_carry;
    t_months;
    t_year;
    t_read_halt;
    t_write_prio;
    t_osc_stop;
    t_freq;
    t_batt;
    t_unused;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule